// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes an incoming byte stream of network frames and files each frame into a memory buffer chosen by a ring of receive descriptors. Every descriptor is a small record with a status halfword, a byte count and a buffer number. The descriptors sit in a register store inside the block, and software reads and writes them through a simple indexed port. The frame payload leaves the block on a byte-wide write port toward an external buffer memory.

A descriptor belongs to the engine only while its empty flag is set. When a frame starts, the engine looks at the descriptor under its ring pointer. If that descriptor is empty, the frame is stored in its buffer, and the count and status are written back as the last byte lands. The ring pointer then steps forward, or goes back to slot 0. If the descriptor is not empty, the engine drops the frame and halts. It stays halted until software writes a resume key to the poll input. Frames that arrive while the engine is halted are dropped and counted. Address filtering and checksum checking belong to other blocks.

Top module: `rxring_engine`

## Requirements
- R1: A frame is stored only into the descriptor under the ring pointer, and only if that descriptor's empty flag (status bit 15) is set. The write-back clears bit 15 and keeps software's status bits 14..6 unchanged.
- R2: After a write-back the ring pointer returns to 0 if the used descriptor has its wrap flag (status bit 13) set, or if it is the highest slot NUM_DESC-1. In every other case the pointer goes up by one. The pointer moves only on a write-back.
- R3: A frame that starts while the current descriptor is not empty is dropped, and `rx_active` falls. Reception resumes only after a poll write carrying exactly 0x01000000; any other poll value has no effect. A poll write in the same cycle as a frame's first byte counts for that frame.
- R4: The written-back length counts every byte of the frame, the trailing 4-byte check sequence included. Byte k of a frame goes to buffer address buffer_number*BUF_BYTES + k, with the byte's value.
- R5: `in_err` on any byte of a frame sets status bit 0 in the write-back. The frame is still written back and still uses up its descriptor.
- R6: For a frame longer than MAX_FRAME (default 1518) bytes, only the first MAX_FRAME bytes are stored, the length written back is MAX_FRAME, and status bit 1 is set. Status bits 5..2 are written as 0.
- R7: A dropped frame causes no buffer write and no write-back. It adds one to `ovr_count`, which holds at its maximum value.
- R8: Length and status are written back at the clock edge that stores the frame's last byte, never earlier. `frame_done` is high for one cycle right after that edge.
- R9: Synchronous reset sets the ring pointer to 0, makes the engine inactive, clears every descriptor (empty flag included) and clears `ovr_count`.
- R10: If software writes a descriptor in the same cycle as the engine writes it back, the engine's status and length are kept. Software's buffer number is still taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_err | input | 1 | Receive error on this byte |
| in_data | input | 8 | Stream byte |
| poll_wr | input | 1 | Poll register write strobe |
| poll_data | input | 32 | Poll write value; 0x01000000 resumes |
| sw_wr | input | 1 | Software descriptor write strobe |
| sw_idx | input | IDX_W | Descriptor index for software read and write |
| sw_wstat | input | 16 | Status written by software |
| sw_wlen | input | 16 | Length written by software |
| sw_wbuf | input | BIDX_W | Buffer number written by software |
| sw_rstat | output | 16 | Status of descriptor sw_idx |
| sw_rlen | output | 16 | Length of descriptor sw_idx |
| sw_rbuf | output | BIDX_W | Buffer number of descriptor sw_idx |
| buf_we | output | 1 | Buffer memory byte write strobe |
| buf_addr | output | ADDR_W | Buffer memory byte address |
| buf_wdata | output | 8 | Buffer memory write byte |
| ring_idx | output | IDX_W | Current ring pointer |
| rx_active | output | 1 | Engine running |
| frame_done | output | 1 | One-cycle pulse after a write-back |
| ovr_count | output | OVR_W | Saturating count of dropped frames |

## Verification
A poll write can land in the same cycle as the first byte of a frame. Software can also write a descriptor in the same cycle that the engine writes that descriptor back. The bench drives both cases on purpose. It puts the resume key on the poll port during the start byte, once with an empty descriptor, which must take the frame, and once with an occupied one, which must still drop the frame and halt. It also writes the descriptor being filled during the frame's last byte, then reads that descriptor back and expects the engine's status and length.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

    localparam int STAT_W    = 16;
    localparam int LEN_W     = 16;
    localparam int EMPTY_BIT = 15;
    localparam int WRAP_BIT  = 13;

    // value a poll write must carry to restart reception
    localparam logic [31:0] POLL_KEY = 32'h0100_0000;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [LEN_W-1:0]  len;
    } rxd_t;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_RECV,
        CAP_DROP
    } cap_st_e;

    // completed status: ownership returned, software bits kept, error code in low bits
    function automatic logic [STAT_W-1:0] done_status(
        input logic [8:0] keep,
        input logic       too_long,
        input logic       bad_frame
    );
        return {1'b0, keep, 4'b0000, too_long, bad_frame};
    endfunction

endpackage

// File: rtl/rxring_desc_store.sv
module rxring_desc_store
    import rxring_pkg::*;
#(
    parameter int NUM_DESC = 8,
    parameter int IDX_W    = 3,
    parameter int BIDX_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_wr,
    input  logic [IDX_W-1:0]  sw_idx,
    input  rxd_t              sw_wdesc,
    input  logic [BIDX_W-1:0] sw_wbuf,
    output rxd_t              sw_rdesc,
    output logic [BIDX_W-1:0] sw_rbuf,
    input  logic [IDX_W-1:0]  eng_idx,
    output logic [STAT_W-1:0] eng_rstat,
    output logic [BIDX_W-1:0] eng_rbuf,
    input  logic              eng_wr,
    input  rxd_t              eng_wdesc
);

    rxd_t              slot_arr [NUM_DESC];
    logic [BIDX_W-1:0] bidx_arr [NUM_DESC];

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_slot
        rxd_t              slot_q;
        logic [BIDX_W-1:0] bidx_q;
        logic              hit_sw;
        logic              hit_eng;

        assign hit_sw  = sw_wr  && (sw_idx  == IDX_W'(g));
        assign hit_eng = eng_wr && (eng_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
                bidx_q <= '0;
            end else begin
                // engine write-back has priority over software on status and length
                if (hit_eng) begin
                    slot_q <= eng_wdesc;
                end else if (hit_sw) begin
                    slot_q <= sw_wdesc;
                end
                if (hit_sw) begin
                    bidx_q <= sw_wbuf;
                end
            end
        end

        assign slot_arr[g] = slot_q;
        assign bidx_arr[g] = bidx_q;
    end

    always_comb begin
        sw_rdesc  = '0;
        sw_rbuf   = '0;
        eng_rstat = '0;
        eng_rbuf  = '0;
        if (32'(sw_idx) < NUM_DESC) begin
            sw_rdesc = slot_arr[sw_idx];
            sw_rbuf  = bidx_arr[sw_idx];
        end
        if (32'(eng_idx) < NUM_DESC) begin
            eng_rstat = slot_arr[eng_idx].stat;
            eng_rbuf  = bidx_arr[eng_idx];
        end
    end

endmodule

// File: rtl/rxring_sequencer.sv
module rxring_sequencer
    import rxring_pkg::*;
#(
    parameter int NUM_DESC = 8,
    parameter int IDX_W    = 3,
    parameter int OVR_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             poll_wr,
    input  logic [31:0]      poll_data,
    input  logic             sof_evt,
    input  logic             cur_empty,
    input  logic             cur_wrap,
    input  logic             wb_en,
    output logic             accept,
    output logic [IDX_W-1:0] ring_idx,
    output logic             rx_active,
    output logic [OVR_W-1:0] ovr_count,
    output logic             frame_done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

    logic             poll_hit;
    logic             go;
    logic             drop;
    logic [IDX_W-1:0] idx_next;

    assign poll_hit = poll_wr && (poll_data == POLL_KEY);
    // a poll in the start-byte cycle already counts for that frame
    assign go       = (rx_active || poll_hit) && cur_empty;
    assign accept   = sof_evt && go;
    assign drop     = sof_evt && !go;
    assign idx_next = (cur_wrap || ring_idx == LAST_IDX) ? '0 : ring_idx + IDX_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_idx   <= '0;
            rx_active  <= 1'b0;
            ovr_count  <= '0;
            frame_done <= 1'b0;
        end else begin
            rx_active  <= sof_evt ? go : (rx_active || poll_hit);
            frame_done <= wb_en;
            if (wb_en) begin
                ring_idx <= idx_next;
            end
            if (drop && ovr_count != '1) begin
                ovr_count <= ovr_count + OVR_W'(1);
            end
        end
    end

endmodule

// File: rtl/rxring_capture.sv
module rxring_capture
    import rxring_pkg::*;
#(
    parameter int MAX_FRAME = 1518,
    parameter int BUF_BYTES = 1520,
    parameter int BIDX_W    = 4,
    parameter int ADDR_W    = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_err,
    input  logic [7:0]        in_data,
    input  logic              accept,
    input  logic [8:0]        cur_keep,
    input  logic [BIDX_W-1:0] cur_buf,
    output logic              sof_evt,
    output logic              wb_en,
    output rxd_t              wb_desc,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_wdata
);

    localparam logic [LEN_W-1:0] CAP_LIM = LEN_W'(MAX_FRAME);

    cap_st_e           st_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [BIDX_W-1:0] buf_q;
    logic              err_q;
    logic              long_q;

    logic              receiving;
    logic              take;
    logic              room;
    logic [LEN_W-1:0]  cnt_cur;
    logic [BIDX_W-1:0] buf_sel;
    logic              err_now;
    logic              long_now;

    assign receiving = (st_q == CAP_RECV);
    assign sof_evt   = (st_q == CAP_IDLE) && in_valid && in_sof;
    assign take      = (receiving && in_valid) || accept;
    assign cnt_cur   = receiving ? cnt_q : '0;
    assign room      = cnt_cur < CAP_LIM;
    assign buf_sel   = receiving ? buf_q : cur_buf;
    assign err_now   = (receiving && err_q) || (in_valid && in_err);
    assign long_now  = (receiving && long_q) || (take && !room);

    assign buf_we    = take && room;
    assign buf_addr  = ADDR_W'(buf_sel) * ADDR_W'(BUF_BYTES) + ADDR_W'(cnt_cur);
    assign buf_wdata = in_data;

    // write-back rides on the same edge as the last byte's store
    assign wb_en        = take && in_eof;
    assign wb_desc.len  = cnt_cur + (buf_we ? LEN_W'(1) : LEN_W'(0));
    assign wb_desc.stat = done_status(cur_keep, long_now, err_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= CAP_IDLE;
            cnt_q  <= '0;
            buf_q  <= '0;
            err_q  <= 1'b0;
            long_q <= 1'b0;
        end else begin
            unique case (st_q)
                CAP_IDLE: begin
                    if (sof_evt && !in_eof) begin
                        if (accept) begin
                            st_q   <= CAP_RECV;
                            cnt_q  <= wb_desc.len;
                            buf_q  <= cur_buf;
                            err_q  <= err_now;
                            long_q <= long_now;
                        end else begin
                            st_q <= CAP_DROP;
                        end
                    end
                end
                CAP_RECV: begin
                    if (in_valid) begin
                        cnt_q  <= wb_desc.len;
                        err_q  <= err_now;
                        long_q <= long_now;
                        if (in_eof) begin
                            st_q <= CAP_IDLE;
                        end
                    end
                end
                CAP_DROP: begin
                    if (in_valid && in_eof) begin
                        st_q <= CAP_IDLE;
                    end
                end
                default: st_q <= CAP_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rxring_engine.sv
module rxring_engine
    import rxring_pkg::*;
#(
    parameter  int NUM_DESC  = 8,
    parameter  int BIDX_W    = 4,
    parameter  int BUF_BYTES = 1520,
    parameter  int MAX_FRAME = 1518,
    parameter  int OVR_W     = 16,
    localparam int IDX_W     = $clog2(NUM_DESC),
    localparam int ADDR_W    = $clog2((2 ** BIDX_W) * BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_err,
    input  logic [7:0]        in_data,
    input  logic              poll_wr,
    input  logic [31:0]       poll_data,
    input  logic              sw_wr,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [15:0]       sw_wstat,
    input  logic [15:0]       sw_wlen,
    input  logic [BIDX_W-1:0] sw_wbuf,
    output logic [15:0]       sw_rstat,
    output logic [15:0]       sw_rlen,
    output logic [BIDX_W-1:0] sw_rbuf,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    output logic [IDX_W-1:0]  ring_idx,
    output logic              rx_active,
    output logic              frame_done,
    output logic [OVR_W-1:0]  ovr_count
);

    rxd_t              sw_wdesc;
    rxd_t              sw_rdesc;
    rxd_t              wb_desc;
    logic [STAT_W-1:0] eng_stat;
    logic [BIDX_W-1:0] eng_buf;
    logic              cur_empty;
    logic              cur_wrap;
    logic              sof_evt;
    logic              accept;
    logic              wb_en;
    logic              unused_low_stat;

    assign sw_wdesc.stat   = sw_wstat;
    assign sw_wdesc.len    = sw_wlen;
    assign sw_rstat        = sw_rdesc.stat;
    assign sw_rlen         = sw_rdesc.len;
    assign cur_empty       = eng_stat[EMPTY_BIT];
    assign cur_wrap        = eng_stat[WRAP_BIT];
    assign unused_low_stat = ^eng_stat[5:0];

    rxring_desc_store #(
        .NUM_DESC (NUM_DESC),
        .IDX_W    (IDX_W),
        .BIDX_W   (BIDX_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .sw_wr     (sw_wr),
        .sw_idx    (sw_idx),
        .sw_wdesc  (sw_wdesc),
        .sw_wbuf   (sw_wbuf),
        .sw_rdesc  (sw_rdesc),
        .sw_rbuf   (sw_rbuf),
        .eng_idx   (ring_idx),
        .eng_rstat (eng_stat),
        .eng_rbuf  (eng_buf),
        .eng_wr    (wb_en),
        .eng_wdesc (wb_desc)
    );

    rxring_sequencer #(
        .NUM_DESC (NUM_DESC),
        .IDX_W    (IDX_W),
        .OVR_W    (OVR_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .poll_wr    (poll_wr),
        .poll_data  (poll_data),
        .sof_evt    (sof_evt),
        .cur_empty  (cur_empty),
        .cur_wrap   (cur_wrap),
        .wb_en      (wb_en),
        .accept     (accept),
        .ring_idx   (ring_idx),
        .rx_active  (rx_active),
        .ovr_count  (ovr_count),
        .frame_done (frame_done)
    );

    rxring_capture #(
        .MAX_FRAME (MAX_FRAME),
        .BUF_BYTES (BUF_BYTES),
        .BIDX_W    (BIDX_W),
        .ADDR_W    (ADDR_W)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_err    (in_err),
        .in_data   (in_data),
        .accept    (accept),
        .cur_keep  (eng_stat[14:6]),
        .cur_buf   (eng_buf),
        .sof_evt   (sof_evt),
        .wb_en     (wb_en),
        .wb_desc   (wb_desc),
        .buf_we    (buf_we),
        .buf_addr  (buf_addr),
        .buf_wdata (buf_wdata)
    );

endmodule

// File: rtl/rxring_engine_chk.sv
module rxring_engine_chk #(
    parameter int NUM_DESC  = 8,
    parameter int IDX_W     = 3,
    parameter int MAX_FRAME = 1518,
    parameter int OVR_W     = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             wb_en,
    input logic [15:0]      wb_len,
    input logic             sof_evt,
    input logic             accept,
    input logic             cur_empty,
    input logic             cur_wrap,
    input logic [IDX_W-1:0] ring_idx,
    input logic             rx_active,
    input logic [OVR_W-1:0] ovr_count
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

    AST_WB_OWNED_ONLY: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> cur_empty); // R1

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        wb_en && cur_wrap |=> ring_idx == '0); // R2

    AST_STEP_NEXT: assert property (@(posedge clk) disable iff (rst)
        wb_en && !cur_wrap && ring_idx != LAST_IDX |=> ring_idx == $past(ring_idx) + IDX_W'(1)); // R2

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wb_en |=> $stable(ring_idx)); // R2

    AST_HALT_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        sof_evt && !cur_empty |=> !rx_active); // R3

    AST_LEN_CAPPED: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> wb_len <= 16'(MAX_FRAME)); // R6

    AST_DROP_NO_WB: assert property (@(posedge clk) disable iff (rst)
        sof_evt && !accept |-> !wb_en); // R7

    AST_DROP_COUNTED: assert property (@(posedge clk) disable iff (rst)
        sof_evt && !accept && ovr_count != '1 |=> ovr_count == $past(ovr_count) + OVR_W'(1)); // R7

endmodule

bind rxring_engine rxring_engine_chk #(
    .NUM_DESC  (NUM_DESC),
    .IDX_W     (IDX_W),
    .MAX_FRAME (MAX_FRAME),
    .OVR_W     (OVR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wb_en     (wb_en),
    .wb_len    (wb_desc.len),
    .sof_evt   (sof_evt),
    .accept    (accept),
    .cur_empty (cur_empty),
    .cur_wrap  (cur_wrap),
    .ring_idx  (ring_idx),
    .rx_active (rx_active),
    .ovr_count (ovr_count)
);

// File: tb/tb_rxring_engine.sv
module tb_rxring_engine;

    localparam int NUM_DESC  = 8;
    localparam int BIDX_W    = 4;
    localparam int BUF_BYTES = 1520;
    localparam int MAX_FRAME = 1518;
    localparam int OVR_W     = 16;
    localparam int IDX_W     = 3;
    localparam int ADDR_W    = 15;
    localparam logic [15:0] F_EMPTY = 16'h8000;
    localparam logic [15:0] F_WRAP  = 16'h2000;
    localparam logic [31:0] KEY     = 32'h0100_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 0, in_sof = 0, in_eof = 0, in_err = 0;
    logic [7:0] in_data = '0;
    logic poll_wr = 0;
    logic [31:0] poll_data = '0;
    logic sw_wr = 0;
    logic [IDX_W-1:0] sw_idx = '0;
    logic [15:0] sw_wstat = '0, sw_wlen = '0;
    logic [BIDX_W-1:0] sw_wbuf = '0;
    logic [15:0] sw_rstat, sw_rlen;
    logic [BIDX_W-1:0] sw_rbuf;
    logic buf_we;
    logic [ADDR_W-1:0] buf_addr;
    logic [7:0] buf_wdata;
    logic [IDX_W-1:0] ring_idx;
    logic rx_active, frame_done;
    logic [OVR_W-1:0] ovr_count;

    int n_chk = 0;
    int n_err = 0;
    int frame_no = 0;

    // bench model of the ring
    logic [15:0]       m_stat  [NUM_DESC];
    logic [BIDX_W-1:0] m_buf   [NUM_DESC];
    int                m_idx   = 0;
    bit                m_active = 0;
    int                m_ovr   = 0;

    always #5 clk = ~clk;

    rxring_engine #(
        .NUM_DESC (NUM_DESC), .BIDX_W (BIDX_W), .BUF_BYTES (BUF_BYTES),
        .MAX_FRAME (MAX_FRAME), .OVR_W (OVR_W)
    ) dut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_sof (in_sof),
        .in_eof (in_eof), .in_err (in_err), .in_data (in_data),
        .poll_wr (poll_wr), .poll_data (poll_data), .sw_wr (sw_wr),
        .sw_idx (sw_idx), .sw_wstat (sw_wstat), .sw_wlen (sw_wlen),
        .sw_wbuf (sw_wbuf), .sw_rstat (sw_rstat), .sw_rlen (sw_rlen),
        .sw_rbuf (sw_rbuf), .buf_we (buf_we), .buf_addr (buf_addr),
        .buf_wdata (buf_wdata), .ring_idx (ring_idx), .rx_active (rx_active),
        .frame_done (frame_done), .ovr_count (ovr_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_val(input int k, input int f);
        return 8'((k * 13 + f * 29 + 5) & 255);
    endfunction

    function automatic int ring_step(input int idx, input logic [15:0] st);
        if (st[13] || idx == NUM_DESC - 1) return 0;
        return idx + 1;
    endfunction

    task automatic sw_put(input int idx, input logic [15:0] st, input logic [BIDX_W-1:0] b);
        @(negedge clk);
        sw_wr = 1; sw_idx = IDX_W'(idx); sw_wstat = st; sw_wlen = 16'h0; sw_wbuf = b;
        @(negedge clk);
        sw_wr = 0;
        m_stat[idx] = st;
        m_buf[idx]  = b;
    endtask

    task automatic poll(input logic [31:0] v);
        @(negedge clk);
        poll_wr = 1; poll_data = v;
        @(negedge clk);
        poll_wr = 0;
        if (v == KEY) m_active = 1;
    endtask

    // sends one frame; err_pos < 0 means no error byte
    task automatic send(input int len, input int err_pos, input bit poll_sof, input bit collide);
        int  idx0  = m_idx;
        bit  take  = (m_active || poll_sof) && m_stat[idx0][15];
        int  bad   = 0;
        logic [15:0] exp_stat;
        int  exp_len;
        frame_no++;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid = 1; in_sof = (k == 0); in_eof = (k == len - 1);
            in_err = (k == err_pos); in_data = byte_val(k, frame_no);
            poll_wr = poll_sof && (k == 0); poll_data = KEY;
            sw_wr = collide && (k == len - 1); sw_idx = IDX_W'(idx0);
            sw_wstat = F_EMPTY; sw_wlen = 16'h00ff; sw_wbuf = m_buf[idx0];
            #4;
            if (take && k < MAX_FRAME) begin
                if (buf_we !== 1'b1 || buf_wdata !== byte_val(k, frame_no) ||
                    buf_addr !== ADDR_W'(int'(m_buf[idx0]) * BUF_BYTES + k)) bad++;
            end else if (buf_we !== 1'b0) bad++;
        end
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0; in_err = 0; poll_wr = 0; sw_wr = 0;
        #1;
        check(frame_done == take, "R8", "frame_done after last byte", frame_done, take);
        check(bad == 0, take ? "R4" : "R7", "buffer write stream mismatches", bad, 0);
        if (take) begin
            exp_len  = (len > MAX_FRAME) ? MAX_FRAME : len;
            exp_stat = {1'b0, m_stat[idx0][14:6], 4'b0,
                        1'(len > MAX_FRAME), 1'(err_pos >= 0 && err_pos < len)};
            m_stat[idx0] = exp_stat;
            m_idx = ring_step(idx0, {2'b0, exp_stat[13], 13'b0});
            m_active = 1;
            sw_idx = IDX_W'(idx0);
            #1;
            check(sw_rstat == exp_stat, collide ? "R10" : ((err_pos >= 0) ? "R5" : "R1"),
                  "written-back status", sw_rstat, exp_stat);
            check(sw_rlen == 16'(exp_len), (len > MAX_FRAME) ? "R6" : "R4",
                  "written-back length", sw_rlen, exp_len);
        end else begin
            m_active = 0;
            if (m_ovr < (1 << OVR_W) - 1) m_ovr++;
            check(ovr_count == OVR_W'(m_ovr), "R7", "drop counter", ovr_count, m_ovr);
        end
        check(ring_idx == IDX_W'(m_idx), "R2", "ring pointer", ring_idx, m_idx);
        check(rx_active == m_active, "R3", "active flag", rx_active, m_active);
    endtask

    task automatic give_back(input int idx);
        sw_put(idx, (m_stat[idx] | F_EMPTY) & 16'hffc0, m_buf[idx]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check(ring_idx == 0, "R9", "pointer after reset", ring_idx, 0);
        check(rx_active == 0, "R9", "active after reset", rx_active, 0);
        check(ovr_count == 0, "R9", "drop count after reset", ovr_count, 0);
        sw_idx = 3'd5;
        #1;
        check(sw_rstat == 16'h0, "R9", "descriptor cleared by reset", sw_rstat, 0);

        // ring of four via wrap flag on slot 3; odd slots carry a software marker bit 10
        for (int i = 0; i < NUM_DESC; i++)
            sw_put(i, F_EMPTY | ((i % 2) ? 16'h0400 : 16'h0) | ((i == 3) ? F_WRAP : 16'h0),
                   BIDX_W'(i * 3 + 1));

        send(10, -1, 0, 0);          // R7: engine not yet started
        poll(32'h0000_0001);
        #1;
        check(rx_active == 0, "R3", "wrong poll value ignored", rx_active, 0);
        poll(KEY);
        #1;
        check(rx_active == 1, "R3", "resume key starts engine", rx_active, 1);

        send(1, -1, 0, 0);           // R1: single byte frame
        send(64, 10, 0, 0);          // R5: error mid-frame
        send(60, 59, 0, 0);          // R5: error on last byte
        send(48, -1, 0, 0);          // R2: slot 3 wraps to 0

        void'($urandom(32'd4242));
        for (int n = 0; n < 16; n++) begin
            int ln = 1 + int'($urandom % 120);
            int ep = ($urandom % 4 == 0) ? int'($urandom % ln) : -1;
            give_back(m_idx);
            send(ln, ep, 0, 0);
        end

        send(20, -1, 0, 0);          // R3: slot not returned, halt
        send(20, -1, 0, 0);          // R7: dropped while halted
        give_back(m_idx);
        send(30, -1, 1, 0);          // R3: poll in start cycle takes the frame
        send(30, -1, 1, 0);          // R3: poll in start cycle, slot occupied, still halts

        give_back(m_idx);
        poll(KEY);
        send(1530, -1, 0, 0);        // R6: over-length truncated

        // open the full ring: no wrap on slot 3, slot 7 is the natural end
        for (int i = 0; i < NUM_DESC; i++)
            sw_put(i, F_EMPTY | ((i % 2) ? 16'h0400 : 16'h0), m_buf[i]);
        for (int n = 0; n < 10; n++) begin
            if (!m_stat[m_idx][15]) give_back(m_idx);
            send(5 + n, -1, 0, n == 4);  // R10 on one frame
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule